// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block sits between a memory-mapped register bus and an external eight-input analog-to-digital converter. Software fills a control word that chooses which inputs take part, how far the bus clock is slowed to make the converter clock, the requested accuracy, whether the block is powered up, and what starts a conversion. A conversion can start on a software command, on a chosen edge of one of five external trigger pins, or, in burst mode, one after another across all selected inputs without pause.

Toward the converter the block issues a clock enable, a channel index held for the whole conversion, and a one-cycle start pulse. The converter answers with a done strobe and a result. Each result lands in the register of its channel and in a global result register. Per-channel flags record a fresh result and a result that overwrote an unread one. A per-channel mask chooses which fresh-result flags drive the interrupt line.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control word at byte offset 0x00 holds the channel bitmap in bits 7:0, a divider D in bits 15:8, burst enable in bit 16, accuracy in bits 19:17, power-up in bit 21, the start code in bits 26:24 and edge polarity in bit 27 (0 rising, 1 falling); it reads back as written. While powered up, `conv_clk_en` pulses once every D+1 clock cycles.
- R2: While control bit 21 is 0, no `conv_start` is issued and `conv_clk_en` stays low.
- R3: Writing the control word with start code 1 and burst off starts exactly one conversion, on the lowest selected channel; `conv_start` is a one-cycle pulse and never names an unselected channel.
- R4: With burst on, conversions follow each other over the selected channels in ascending order, wrapping from the highest to the lowest; the start code has no effect while burst is on.
- R5: A channel result register at offset 0x10 + 4·n holds the last result of channel n in bits 15:6, its overrun flag in bit 30 and its fresh-result flag in bit 31.
- R6: A result arriving while the channel's fresh-result flag is set sets its overrun flag; reading the channel register clears both flags.
- R7: Start codes 2 to 6 select trigger pin 0 to 4; one conversion starts on the selected pin's edge of the polarity in bit 27, after two synchronising flops. Other pins and the other edge start nothing.
- R8: A trigger edge that arrives while a conversion is in progress is dropped.
- R9: The status register at 0x30 shows the fresh-result flags in bits 7:0, overrun flags in bits 15:8 and the interrupt in bit 16. `irq` is high exactly while a channel has its fresh-result flag set and its bit in the enable register at 0x0C.
- R10: The global register at 0x04 holds the latest result in bits 15:6, its channel in bits 26:24 and a fresh flag in bit 31 that reading it clears.
- R11: `conv_acc` follows control bits 19:17.
- R12: After reset all registers read zero, `irq`, `conv_start` and `conv_clk_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| trig_in | input | NTRIG | External trigger pins, asynchronous |
| conv_clk_en | output | 1 | Converter clock enable pulse |
| conv_start | output | 1 | One-cycle conversion start |
| conv_ch | output | CH_W | Channel being converted |
| conv_acc | output | 3 | Requested accuracy code |
| conv_done | input | 1 | Converter result valid strobe |
| conv_result | input | RES_W | Converter result |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: eight channels, five trigger pins, a 10-bit result and an 8-bit divider. Eight channels let a burst bitmap include channel 7 and so reach the wrap back to the lowest channel, and five pins let every trigger start code be walked. A bench converter model with a short, adjustable latency makes an overwrite of an unread result and a trigger during a long conversion easy to reach.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
   // register byte offsets
   localparam logic [5:0] A_CTRL   = 6'h00;
   localparam logic [5:0] A_GLOBAL = 6'h04;
   localparam logic [5:0] A_INTEN  = 6'h0C;
   localparam logic [5:0] A_CHAN0  = 6'h10;
   localparam logic [5:0] A_STATUS = 6'h30;

   // control word field positions
   localparam int CB_MASK  = 0;
   localparam int CB_DIV   = 8;
   localparam int CB_BURST = 16;
   localparam int CB_ACC   = 17;
   localparam int CB_OP    = 21;
   localparam int CB_START = 24;
   localparam int CB_EDGE  = 27;

   // result word field positions
   localparam int DB_RES_MSB = 15;
   localparam int DB_CH      = 24;
   localparam int DB_OVR     = 30;
   localparam int DB_DONE    = 31;

   // status word field positions
   localparam int SB_OVR = 8;
   localparam int SB_IRQ = 16;

   // start codes
   localparam logic [2:0] START_NOW   = 3'd1;
   localparam int         START_TRIG0 = 2;
endpackage

// File: rtl/adc_clk_div.sv
`timescale 1ns/1ps
module adc_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q >= div) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_trig_sel.sv
`timescale 1ns/1ps
module adc_trig_sel
   import adc_seq_pkg::*;
#(
   parameter int NTRIG = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NTRIG-1:0] trig_in,
   input  logic [2:0]       code,
   input  logic             fall,
   input  logic             enable,
   output logic             req
);
   logic [NTRIG-1:0] sync1_q, sync2_q, prev_q;
   logic [NTRIG-1:0] edge_v, hit_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1_q <= '0;
         sync2_q <= '0;
         prev_q  <= '0;
      end else begin
         sync1_q <= trig_in;
         sync2_q <= sync1_q;
         prev_q  <= sync2_q;
      end
   end

   assign edge_v = fall ? (prev_q & ~sync2_q) : (sync2_q & ~prev_q);

   for (genvar k = 0; k < NTRIG; k++) begin : g_pin
      assign hit_v[k] = edge_v[k] && (code == 3'(START_TRIG0 + k));
   end

   assign req = enable && (|hit_v);
endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq #(
   parameter int NCH  = 8,
   parameter int CH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [NCH-1:0]  mask,
   input  logic            burst,
   input  logic            req,
   input  logic            conv_done,
   output logic            conv_start,
   output logic [CH_W-1:0] conv_ch,
   output logic            busy,
   output logic            wb
);
   logic [CH_W-1:0] last_q, low_ch, nxt_ch;
   logic            found, go;

   always_comb begin
      low_ch = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (mask[i]) low_ch = CH_W'(i);
      end
      nxt_ch = low_ch;
      found  = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         if (!found && mask[i] && (i > int'(last_q))) begin
            nxt_ch = CH_W'(i);
            found  = 1'b1;
         end
      end
   end

   assign go = run && (|mask) && !busy && (burst || req);
   assign wb = busy && conv_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         conv_start <= 1'b0;
         conv_ch    <= '0;
         last_q     <= CH_W'(NCH - 1);
      end else begin
         conv_start <= go;
         if (go) begin
            busy    <= 1'b1;
            conv_ch <= burst ? nxt_ch : low_ch;
            if (burst) last_q <= nxt_ch;
         end else if (wb) begin
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int  NCH   = 8,
   parameter int  NTRIG = 5,
   parameter int  RES_W = 10,
   parameter int  DIV_W = 8,
   localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [5:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [NTRIG-1:0] trig_in,
   output logic             conv_clk_en,
   output logic             conv_start,
   output logic [CH_W-1:0]  conv_ch,
   output logic [2:0]       conv_acc,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_result,
   output logic             irq
);
   // elaboration-time parameter checks
   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("NCH must lie in 1..8");
   end
   if (NTRIG < 1 || NTRIG > 5) begin : g_bad_ntrig
      $error("NTRIG must lie in 1..5");
   end
   if (RES_W < 1 || RES_W > 10) begin : g_bad_res
      $error("RES_W must lie in 1..10");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must lie in 1..8");
   end

   logic rd_en, wr_en, wr_ctrl, wr_inten, rd_glb;
   assign rd_en    = bus_sel && !bus_wr;
   assign wr_en    = bus_sel && bus_wr;
   assign wr_ctrl  = wr_en && (bus_addr == A_CTRL);
   assign wr_inten = wr_en && (bus_addr == A_INTEN);
   assign rd_glb   = rd_en && (bus_addr == A_GLOBAL);

   // control fields
   logic [NCH-1:0]   mask_q;
   logic [DIV_W-1:0] div_q;
   logic             burst_q, op_q, fall_q, sw_req_q;
   logic [2:0]       acc_q, start_q;
   logic [NCH-1:0]   inten_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         div_q    <= '0;
         burst_q  <= 1'b0;
         acc_q    <= '0;
         op_q     <= 1'b0;
         start_q  <= '0;
         fall_q   <= 1'b0;
         sw_req_q <= 1'b0;
         inten_q  <= '0;
      end else begin
         sw_req_q <= wr_ctrl && (bus_wdata[CB_START +: 3] == START_NOW);
         if (wr_ctrl) begin
            mask_q  <= bus_wdata[CB_MASK +: NCH];
            div_q   <= bus_wdata[CB_DIV +: DIV_W];
            burst_q <= bus_wdata[CB_BURST];
            acc_q   <= bus_wdata[CB_ACC +: 3];
            op_q    <= bus_wdata[CB_OP];
            start_q <= bus_wdata[CB_START +: 3];
            fall_q  <= bus_wdata[CB_EDGE];
         end
         if (wr_inten) inten_q <= bus_wdata[NCH-1:0];
      end
   end

   wire unused_wdata = ^bus_wdata;

   // converter-side helpers
   logic trig_req, seq_busy, seq_wb;

   adc_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (op_q),
      .div   (div_q),
      .tick  (conv_clk_en)
   );

   adc_trig_sel #(.NTRIG(NTRIG)) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_in (trig_in),
      .code    (start_q),
      .fall    (fall_q),
      .enable  (!burst_q),
      .req     (trig_req)
   );

   adc_scan_seq #(.NCH(NCH), .CH_W(CH_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (op_q),
      .mask       (mask_q),
      .burst      (burst_q),
      .req        (sw_req_q || trig_req),
      .conv_done  (conv_done),
      .conv_start (conv_start),
      .conv_ch    (conv_ch),
      .busy       (seq_busy),
      .wb         (seq_wb)
   );

   assign conv_acc = acc_q;

   // per-channel result storage
   logic [RES_W-1:0] res_a  [NCH];
   logic             done_a [NCH];
   logic             ovr_a  [NCH];
   logic [NCH-1:0]   done_v, ovr_v, rd_ch;

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      assign rd_ch[n]  = rd_en && (bus_addr == A_CHAN0 + 6'(4 * n));
      assign done_v[n] = done_a[n];
      assign ovr_v[n]  = ovr_a[n];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_a[n]  <= '0;
            done_a[n] <= 1'b0;
            ovr_a[n]  <= 1'b0;
         end else if (seq_wb && (conv_ch == CH_W'(n))) begin
            res_a[n]  <= conv_result;
            done_a[n] <= 1'b1;
            ovr_a[n]  <= (ovr_a[n] || done_a[n]) && !rd_ch[n];
         end else if (rd_ch[n]) begin
            done_a[n] <= 1'b0;
            ovr_a[n]  <= 1'b0;
         end
      end
   end

   // global latest result
   logic [RES_W-1:0] gres_q;
   logic [CH_W-1:0]  gch_q;
   logic             gdone_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gres_q  <= '0;
         gch_q   <= '0;
         gdone_q <= 1'b0;
      end else if (seq_wb) begin
         gres_q  <= conv_result;
         gch_q   <= conv_ch;
         gdone_q <= 1'b1;
      end else if (rd_glb) begin
         gdone_q <= 1'b0;
      end
   end

   assign irq = |(done_v & inten_q);

   // read multiplexer
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[CB_MASK +: NCH]   = mask_q;
            bus_rdata[CB_DIV +: DIV_W]  = div_q;
            bus_rdata[CB_BURST]         = burst_q;
            bus_rdata[CB_ACC +: 3]      = acc_q;
            bus_rdata[CB_OP]            = op_q;
            bus_rdata[CB_START +: 3]    = start_q;
            bus_rdata[CB_EDGE]          = fall_q;
         end
         A_GLOBAL: begin
            bus_rdata[DB_RES_MSB -: RES_W] = gres_q;
            bus_rdata[DB_CH +: CH_W]       = gch_q;
            bus_rdata[DB_DONE]             = gdone_q;
         end
         A_INTEN: bus_rdata[NCH-1:0] = inten_q;
         A_STATUS: begin
            bus_rdata[NCH-1:0]       = done_v;
            bus_rdata[SB_OVR +: NCH] = ovr_v;
            bus_rdata[SB_IRQ]        = irq;
         end
         default: begin
            for (int n = 0; n < NCH; n++) begin
               if (bus_addr == A_CHAN0 + 6'(4 * n)) begin
                  bus_rdata[DB_RES_MSB -: RES_W] = res_a[n];
                  bus_rdata[DB_OVR]              = ovr_a[n];
                  bus_rdata[DB_DONE]             = done_a[n];
               end
            end
         end
      endcase
   end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk #(
   parameter int NCH  = 8,
   parameter int CH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            conv_start,
   input logic [CH_W-1:0] conv_ch,
   input logic            busy,
   input logic            op,
   input logic [NCH-1:0]  chmask,
   input logic [NCH-1:0]  done_v,
   input logic [NCH-1:0]  ovr_v,
   input logic            wb,
   input logic            gdone
);
   logic [NCH-1:0] mask_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_d <= '0;
      else        mask_d <= chmask;
   end

   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_start_powered_R2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $past(op));

   assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !$past(busy));

   assert_start_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> mask_d[conv_ch]);

   assert_overrun_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_v & ~$past(ovr_v) & ~$past(done_v)) == '0);

   assert_global_fresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wb |=> gdone);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_start (conv_start),
   .conv_ch    (conv_ch),
   .busy       (seq_busy),
   .op         (op_q),
   .chmask     (mask_q),
   .done_v     (done_v),
   .ovr_v      (ovr_v),
   .wb         (seq_wb),
   .gdone      (gdone_q)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [4:0]  trig_in = '0;
   logic        conv_clk_en, conv_start, conv_done = 1'b0, irq;
   logic [2:0]  conv_ch, conv_acc;
   logic [9:0]  conv_result = '0;

   int nchecks = 0, nerr = 0;
   bit fin = 1'b0;

   always #2.5 clk = ~clk;

   adc_seq_ctrl i_adc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .trig_in(trig_in), .conv_clk_en(conv_clk_en), .conv_start(conv_start),
      .conv_ch(conv_ch), .conv_acc(conv_acc), .conv_done(conv_done),
      .conv_result(conv_result), .irq(irq)
   );

   // converter model
   int         lat = 3;
   int         pend = 0;
   int         nstarts = 0;
   logic [2:0] pend_ch = '0;
   logic [9:0] rbase = '0;
   logic [2:0] slog [64];

   always @(negedge clk) begin
      conv_done <= 1'b0;
      if (pend != 0) begin
         pend <= pend - 1;
         if (pend == 1) begin
            conv_done   <= 1'b1;
            conv_result <= rbase ^ {pend_ch, 7'b0};
         end
      end else if (rst_n && conv_start) begin
         pend             <= lat;
         pend_ch          <= conv_ch;
         slog[nstarts%64] <= conv_ch;
         nstarts          <= nstarts + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchecks++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] mk(input logic [7:0] m, input logic [7:0] dv, input logic bu,
                                      input logic [2:0] ac, input logic op, input logic [2:0] st,
                                      input logic fe);
      return {4'b0, fe, st, 2'b0, op, 1'b0, ac, bu, dv, m};
   endfunction

   function automatic logic [2:0] lowest(input logic [7:0] m);
      logic [2:0] r = 3'd0;
      for (int i = 7; i >= 0; i--) if (m[i]) r = 3'(i);
      return r;
   endfunction

   function automatic logic [31:0] chword(input logic d, input logic o, input logic [9:0] r);
      return {d, o, 14'b0, r, 6'b0};
   endfunction

   // stimulus table: {channel bitmap, converter result base}
   localparam logic [17:0] VEC [6] = '{
      {8'h01, 10'h155}, {8'h80, 10'h2AA}, {8'h28, 10'h0F0},
      {8'hFF, 10'h3FF}, {8'h40, 10'h001}, {8'h06, 10'h200}
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         nchecks++; nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [7:0]  m;
      logic [2:0]  ch;
      logic [9:0]  rv;
      int          base, n1, cnt, t0, t1, t2;
      logic [2:0]  exp_seq [5];

      waitc(3);
      rst_n = 1'b1;
      waitc(2);

      // R12 reset state
      bread(6'h00, rd); chk("R12 ctrl reset", rd, 0);
      bread(6'h30, rd); chk("R12 status reset", rd, 0);
      bread(6'h04, rd); chk("R12 global reset", rd, 0);
      bread(6'h0C, rd); chk("R12 enable reset", rd, 0);
      bread(6'h10, rd); chk("R12 chan0 reset", rd, 0);
      chk("R12 irq/start/clk reset", {29'b0, irq, conv_start, conv_clk_en}, 0);

      // R1 control layout readback
      bwrite(6'h00, mk(8'hA5, 8'h3C, 1'b1, 3'd5, 1'b0, 3'd6, 1'b1));
      bread(6'h00, rd); chk("R1 ctrl readback", rd, mk(8'hA5, 8'h3C, 1'b1, 3'd5, 1'b0, 3'd6, 1'b1));
      // R11 accuracy passthrough
      chk("R11 accuracy out", {29'b0, conv_acc}, 5);
      bwrite(6'h00, mk(8'h00, 8'h00, 1'b0, 3'd2, 1'b0, 3'd0, 1'b0));
      chk("R11 accuracy out change", {29'b0, conv_acc}, 2);

      // R1 divider period D+1 = 4
      bwrite(6'h00, mk(8'h00, 8'd3, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0));
      t0 = -1; t1 = -1; t2 = -1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (conv_clk_en) begin
            if (t0 < 0) t0 = i; else if (t1 < 0) t1 = i; else if (t2 < 0) t2 = i;
         end
      end
      chk("R1 divider interval a", t1 - t0, 4);
      chk("R1 divider interval b", t2 - t1, 4);
      bwrite(6'h00, mk(8'h00, 8'd0, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0));
      waitc(2);
      cnt = 0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); if (conv_clk_en) cnt++; end
      chk("R1 divider zero every cycle", cnt, 8);

      // R2 power-down: no clock enable, no start
      bwrite(6'h00, mk(8'h01, 8'd0, 1'b0, 3'd0, 1'b0, 3'd1, 1'b0));
      base = nstarts;
      cnt = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (conv_clk_en) cnt++; end
      chk("R2 no clock when powered down", cnt, 0);
      chk("R2 no start when powered down", nstarts, base);
      bwrite(6'h00, mk(8'h0F, 8'd0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0));
      waitc(20);
      chk("R2 no burst when powered down", nstarts, base);

      // R3 R5 R10 table of single conversions
      for (int v = 0; v < 6; v++) begin
         m = VEC[v][17:10];
         rbase = VEC[v][9:0];
         ch = lowest(m);
         rv = VEC[v][9:0] ^ {ch, 7'b0};
         base = nstarts;
         bwrite(6'h00, mk(m, 8'd1, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
         waitc(12);
         chk("R3 one start per command", nstarts, base + 1);
         chk("R3 lowest selected channel", {29'b0, slog[base%64]}, {29'b0, ch});
         bread(6'h04, rd);
         chk("R10 global word", rd, 32'h8000_0000 | (32'(ch) << 24) | (32'(rv) << 6));
         bread(6'h10 + 6'(4 * ch), rd);
         chk("R5 channel word", rd, chword(1'b1, 1'b0, rv));
         bread(6'h10 + 6'(4 * ch), rd);
         chk("R6 read clears flags", rd, chword(1'b0, 1'b0, rv));
      end
      bread(6'h04, rd);
      chk("R10 global fresh cleared by read", {31'b0, rd[31]}, 0);

      // R6 overrun
      rbase = 10'h111;
      bwrite(6'h00, mk(8'h08, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
      waitc(12);
      rbase = 10'h0AB;
      bwrite(6'h00, mk(8'h08, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
      waitc(12);
      bread(6'h30, rd);
      chk("R9 R6 status with overrun", rd, 32'h0000_0808);
      bread(6'h1C, rd);
      chk("R6 overrun word", rd, chword(1'b1, 1'b1, 10'h0AB ^ 10'h180));
      bread(6'h1C, rd);
      chk("R6 overrun cleared", rd, chword(1'b0, 1'b0, 10'h0AB ^ 10'h180));

      // R4 burst scan, start code 1 has no extra effect
      rbase = 10'h050;
      base = nstarts;
      exp_seq = '{3'd2, 3'd4, 3'd7, 3'd2, 3'd4};
      bwrite(6'h00, mk(8'h94, 8'd0, 1'b1, 3'd0, 1'b1, 3'd1, 1'b0));
      for (int i = 0; i < 200 && nstarts < base + 5; i++) @(negedge clk);
      for (int i = 0; i < 5; i++)
         chk("R4 burst order", {29'b0, slog[(base + i) % 64]}, {29'b0, exp_seq[i]});
      bwrite(6'h00, mk(8'h94, 8'd0, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0));
      waitc(20);
      n1 = nstarts;
      waitc(30);
      chk("R4 burst stops when cleared", nstarts, n1);
      for (int i = 0; i < 8; i++) bread(6'h10 + 6'(4 * i), rd);

      // R7 trigger pins, rising edge
      for (int k = 0; k < 5; k++) begin
         bwrite(6'h00, mk(8'h20, 8'd0, 1'b0, 3'd0, 1'b1, 3'(2 + k), 1'b0));
         waitc(4);
         base = nstarts;
         trig_in[k] = 1'b1;
         waitc(8);
         chk("R7 rising edge starts", nstarts, base + 1);
         chk("R7 trigger channel", {29'b0, slog[base%64]}, 5);
         waitc(10);
         base = nstarts;
         trig_in[k] = 1'b0;
         waitc(10);
         chk("R7 falling edge ignored", nstarts, base);
         bread(6'h24, rd);
      end
      // R7 falling polarity and wrong pin
      bwrite(6'h00, mk(8'h20, 8'd0, 1'b0, 3'd0, 1'b1, 3'd4, 1'b1));
      waitc(4);
      base = nstarts;
      trig_in[2] = 1'b1; waitc(10);
      chk("R7 rising ignored in falling mode", nstarts, base);
      trig_in[2] = 1'b0; waitc(10);
      chk("R7 falling edge starts", nstarts, base + 1);
      trig_in[0] = 1'b1; waitc(10);
      trig_in[0] = 1'b0; waitc(10);
      chk("R7 unselected pin ignored", nstarts, base + 1);

      // R8 trigger during conversion is dropped
      lat = 30;
      bwrite(6'h00, mk(8'h20, 8'd0, 1'b0, 3'd0, 1'b1, 3'd2, 1'b0));
      waitc(4);
      base = nstarts;
      trig_in[0] = 1'b1; waitc(6);
      trig_in[0] = 1'b0; waitc(4);
      trig_in[0] = 1'b1; waitc(6);
      trig_in[0] = 1'b0; waitc(50);
      chk("R8 edge while busy dropped", nstarts, base + 1);
      lat = 3;
      trig_in[0] = 1'b1; waitc(10);
      chk("R8 edge after idle accepted", nstarts, base + 2);
      trig_in[0] = 1'b0; waitc(10);
      for (int i = 0; i < 8; i++) bread(6'h10 + 6'(4 * i), rd);

      // R9 interrupt masking
      bwrite(6'h0C, 32'h0000_0004);
      bread(6'h0C, rd); chk("R9 enable readback", rd, 32'h4);
      bwrite(6'h00, mk(8'h04, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
      waitc(12);
      chk("R9 irq on enabled channel", {31'b0, irq}, 1);
      bread(6'h30, rd); chk("R9 status with irq", rd, 32'h0001_0004);
      bread(6'h18, rd);
      waitc(1);
      chk("R9 irq cleared by channel read", {31'b0, irq}, 0);
      bwrite(6'h00, mk(8'h08, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
      waitc(12);
      chk("R9 irq masked channel", {31'b0, irq}, 0);
      bread(6'h30, rd); chk("R9 status masked channel", rd, 32'h0000_0008);

      fin = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   end
endmodule